// File: doc/BRIEF.md
# Single-Channel Memory-Copy DMA Engine

This block copies a run of data from a source address to a destination address without processor involvement. Software programs a source pointer, a destination pointer, a byte count and a control word through a small register port. It then sets the start bit in the control word. The engine alternates one read and one write on its master side until the byte count is used up. Each pointer can either advance by the transfer size after every transfer or stay fixed, so the engine can walk a memory buffer or repeatedly access a single peripheral data register.

When the count is exhausted, the engine raises a completion flag and stops. If the interrupt enable is set, an interrupt line is asserted. Software acknowledges the interrupt by writing anything to the status register. The block also supports a soft reset. A single write of the reset bit only arms it. A second consecutive control write with that bit set returns the engine to its power-up state, and the arming logic then clears itself.

Top module: `dma_ctrl_engine`

## Requirements
- R1: After reset, every register reads zero (status, source pointer, destination pointer, count, control), both master requests are low, and `irq` is low. The register indices are 0 for status, 1 for source pointer, 2 for destination pointer, 3 for count and 4 for control.
- R2: When control bit 8 is 0, the source pointer advances by the transfer size after each transfer. When bit 8 is 1, every read uses the programmed source address, and the pointer reads back unchanged.
- R3: Control bit 9 governs the destination pointer in the same way: it advances when the bit is 0 and stays fixed when the bit is 1.
- R4: The transfer size comes from a one-hot width field: control bit 0 gives 1 byte, bit 1 gives 2, bit 2 gives 4, bit 10 gives 8 and bit 11 gives 16.
- R5: The count register holds a byte count and drops by the transfer size on each completed write. The engine makes ceil(count/size) transfers and ends with the count at 0. At the end, status bit 0 (done) and status bit 2 (count exhausted) are set, and status bit 1 (busy) is cleared.
- R6: Writing control with bit 3 (start) begins a transfer only if the count is nonzero and exactly one permitted width bit is set. Otherwise busy stays low and no master request appears.
- R7: `irq` is high exactly while done is set and control bit 4 (interrupt enable) is set.
- R8: Any write to the status register clears done, which drops `irq`.
- R9: Two consecutive control writes with bit 12 set reset the engine as a hard reset would, even in the middle of a transfer. A control write with bit 12 clear, placed between them, cancels the first.
- R10: Each transfer is one read followed by one write of the returned data. The two requests are never high together, and a pending write holds its address and data until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | 3 | Register index |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data (combinational on `csr_addr`) |
| m_rd_req | output | 1 | Read request, held until `m_rd_valid` |
| m_rd_addr | output | ADDR_W | Read address |
| m_rd_valid | input | 1 | Read data valid; completes the read |
| m_rd_data | input | DATA_W | Read data |
| m_wr_req | output | 1 | Write request, held until `m_wr_ack` |
| m_wr_addr | output | ADDR_W | Write address |
| m_wr_data | output | DATA_W | Write data |
| m_wr_ack | input | 1 | Write acknowledge |
| irq | output | 1 | Completion interrupt |

## Verification
The assertions assume that the master side raises `m_rd_valid` only while a read is requested and `m_wr_ack` only while a write is requested. They also assume that software does not rewrite the pointers or the count mid-transfer; the engine ignores such writes anyway. The pointer-step and hold checks exclude cycles that carry a register write, because a soft reset may land on such a cycle. The bench responder derives its handshakes from the live request lines at each falling edge, with random gaps. Its software model writes registers only between transfers, except in the deliberate soft-reset-during-transfer case.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;

   localparam int NUM_WIDTHS = 5;
   localparam int SZ_W       = 5;

   localparam logic [2:0] REG_STATUS = 3'd0;
   localparam logic [2:0] REG_RADDR  = 3'd1;
   localparam logic [2:0] REG_WADDR  = 3'd2;
   localparam logic [2:0] REG_LENGTH = 3'd3;
   localparam logic [2:0] REG_CTRL   = 3'd4;

   localparam int CB_BYTE  = 0;
   localparam int CB_HALF  = 1;
   localparam int CB_WORD  = 2;
   localparam int CB_GO    = 3;
   localparam int CB_IEN   = 4;
   localparam int CB_RHOLD = 8;
   localparam int CB_WHOLD = 9;
   localparam int CB_DWORD = 10;
   localparam int CB_QWORD = 11;
   localparam int CB_SRST  = 12;

   typedef enum logic [1:0] {
      X_IDLE  = 2'd0,
      X_READ  = 2'd1,
      X_WRITE = 2'd2
   } xfer_state_e;

   // wsel index i selects a transfer of (1 << i) bytes
   typedef struct packed {
      logic                  rhold;
      logic                  whold;
      logic                  ien;
      logic [NUM_WIDTHS-1:0] wsel;
   } ctrl_t;

endpackage

// File: rtl/dma_width_dec.sv
module dma_width_dec
   import dma_eng_pkg::*;
#(
   parameter logic [NUM_WIDTHS-1:0] ALLOWED = '1
)(
   input  logic [NUM_WIDTHS-1:0] wsel,
   output logic                  legal,
   output logic [SZ_W-1:0]       size
);

   logic [NUM_WIDTHS-1:0] kept;
   logic [NUM_WIDTHS-1:0] banned;

   generate
      for (genvar i = 0; i < NUM_WIDTHS; i++) begin : g_w
         if (ALLOWED[i]) begin : g_on
            assign kept[i]   = wsel[i];
            assign banned[i] = 1'b0;
         end else begin : g_off
            assign kept[i]   = 1'b0;
            assign banned[i] = wsel[i];
         end
      end
   endgenerate

   assign legal = $onehot(wsel) && (banned == '0);

   always_comb begin
      size = '0;
      for (int i = 0; i < NUM_WIDTHS; i++) begin
         if (kept[i]) size = size | SZ_W'(1 << i);
      end
   end

endmodule

// File: rtl/dma_addr_ptr.sv
module dma_addr_ptr
   import dma_eng_pkg::*;
#(
   parameter int ADDR_W = 32
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              srst,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_val,
   input  logic              advance,
   input  logic              hold,
   input  logic [SZ_W-1:0]   size,
   output logic [ADDR_W-1:0] ptr
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr <= '0;
      end else if (srst) begin
         ptr <= '0;
      end else if (load) begin
         ptr <= load_val;
      end else if (advance && !hold) begin
         ptr <= ptr + ADDR_W'(size);
      end
   end

endmodule

// File: rtl/dma_srst_seq.sv
module dma_srst_seq (
   input  logic clk,
   input  logic rst_n,
   input  logic ctrl_we,
   input  logic srst_bit,
   output logic fire
);

   logic armed;

   assign fire = ctrl_we && srst_bit && armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0;
      end else if (ctrl_we) begin
         armed <= srst_bit && !armed;
      end
   end

endmodule

// File: rtl/dma_xfer_fsm.sv
module dma_xfer_fsm
   import dma_eng_pkg::*;
#(
   parameter int DATA_W = 128,
   parameter int LEN_W  = 16
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              srst,
   input  logic              start,
   input  logic [LEN_W-1:0]  len,
   input  logic [SZ_W-1:0]   size,
   input  logic              rd_valid,
   input  logic [DATA_W-1:0] rd_data,
   input  logic              wr_ack,
   output logic              rd_req,
   output logic              wr_req,
   output logic [DATA_W-1:0] wr_data,
   output logic              step,
   output logic              last,
   output logic              busy
);

   xfer_state_e state;

   assign rd_req = (state == X_READ);
   assign wr_req = (state == X_WRITE);
   assign busy   = (state != X_IDLE);
   assign step   = wr_req && wr_ack;
   assign last   = (len <= LEN_W'(size));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= X_IDLE;
         wr_data <= '0;
      end else if (srst) begin
         state   <= X_IDLE;
         wr_data <= '0;
      end else begin
         unique case (state)
            X_IDLE:  if (start) state <= X_READ;
            X_READ:  if (rd_valid) begin
                        wr_data <= rd_data;
                        state   <= X_WRITE;
                     end
            X_WRITE: if (wr_ack) state <= last ? X_IDLE : X_READ;
            default: state <= X_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/dma_ctrl_engine.sv
module dma_ctrl_engine
   import dma_eng_pkg::*;
#(
   parameter int                    ADDR_W  = 32,
   parameter int                    LEN_W   = 16,
   parameter int                    DATA_W  = 128,
   parameter logic [NUM_WIDTHS-1:0] ALLOWED = 5'b11111
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              csr_we,
   input  logic [2:0]        csr_addr,
   input  logic [31:0]       csr_wdata,
   output logic [31:0]       csr_rdata,
   output logic              m_rd_req,
   output logic [ADDR_W-1:0] m_rd_addr,
   input  logic              m_rd_valid,
   input  logic [DATA_W-1:0] m_rd_data,
   output logic              m_wr_req,
   output logic [ADDR_W-1:0] m_wr_addr,
   output logic [DATA_W-1:0] m_wr_data,
   input  logic              m_wr_ack,
   output logic              irq
);

   // elaboration-time parameter checks
   generate
      if (ADDR_W < 8 || ADDR_W > 32) begin : g_bad_addr
         $error("dma_ctrl_engine: ADDR_W must lie in 8..32");
      end
      if (LEN_W < 5 || LEN_W > 32) begin : g_bad_len
         $error("dma_ctrl_engine: LEN_W must lie in 5..32");
      end
      for (genvar i = 0; i < NUM_WIDTHS; i++) begin : g_fit
         if (ALLOWED[i] && DATA_W < (8 << i)) begin : g_bad
            $error("dma_ctrl_engine: DATA_W too narrow for an allowed width");
         end
      end
   endgenerate

   ctrl_t                 ctrl_q;
   logic                  busy;
   logic                  srst_fire;
   logic                  ctrl_we;
   logic                  stat_we;
   logic [NUM_WIDTHS-1:0] wsel_wr;
   logic [NUM_WIDTHS-1:0] wsel_in;
   logic                  legal;
   logic [SZ_W-1:0]       xfer_size;
   logic                  xfer_last;
   logic                  xfer_step;
   logic                  start;
   logic [LEN_W-1:0]      len_q;
   logic                  done_q;
   logic                  lenend_q;
   logic                  rhold;
   logic                  whold;
   logic [ADDR_W-1:0]     ptr [2];

   assign ctrl_we = csr_we && (csr_addr == REG_CTRL);
   assign stat_we = csr_we && (csr_addr == REG_STATUS);
   assign wsel_wr = {csr_wdata[CB_QWORD], csr_wdata[CB_DWORD], csr_wdata[CB_WORD],
                     csr_wdata[CB_HALF], csr_wdata[CB_BYTE]};
   assign wsel_in = (ctrl_we && !busy) ? wsel_wr : ctrl_q.wsel;
   assign rhold   = ctrl_q.rhold;
   assign whold   = ctrl_q.whold;

   dma_srst_seq u_srst (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctrl_we  (ctrl_we),
      .srst_bit (csr_wdata[CB_SRST]),
      .fire     (srst_fire)
   );

   dma_width_dec #(.ALLOWED(ALLOWED)) u_wdec (
      .wsel  (wsel_in),
      .legal (legal),
      .size  (xfer_size)
   );

   assign start = ctrl_we && csr_wdata[CB_GO] && !busy && !srst_fire
                  && (len_q != '0) && legal;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (srst_fire) begin
         ctrl_q <= '0;
      end else if (ctrl_we) begin
         ctrl_q.ien <= csr_wdata[CB_IEN];
         if (!busy) begin
            ctrl_q.rhold <= csr_wdata[CB_RHOLD];
            ctrl_q.whold <= csr_wdata[CB_WHOLD];
            ctrl_q.wsel  <= wsel_wr;
         end
      end
   end

   dma_xfer_fsm #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .srst     (srst_fire),
      .start    (start),
      .len      (len_q),
      .size     (xfer_size),
      .rd_valid (m_rd_valid),
      .rd_data  (m_rd_data),
      .wr_ack   (m_wr_ack),
      .rd_req   (m_rd_req),
      .wr_req   (m_wr_req),
      .wr_data  (m_wr_data),
      .step     (xfer_step),
      .last     (xfer_last),
      .busy     (busy)
   );

   generate
      for (genvar s = 0; s < 2; s++) begin : g_side
         localparam logic [2:0] SEL = (s == 0) ? REG_RADDR : REG_WADDR;
         dma_addr_ptr #(.ADDR_W(ADDR_W)) u_ptr (
            .clk      (clk),
            .rst_n    (rst_n),
            .srst     (srst_fire),
            .load     (csr_we && !busy && (csr_addr == SEL)),
            .load_val (csr_wdata[ADDR_W-1:0]),
            .advance  (xfer_step),
            .hold     ((s == 0) ? rhold : whold),
            .size     (xfer_size),
            .ptr      (ptr[s])
         );
      end
   endgenerate

   assign m_rd_addr = ptr[0];
   assign m_wr_addr = ptr[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         len_q <= '0;
      end else if (srst_fire) begin
         len_q <= '0;
      end else if (csr_we && !busy && (csr_addr == REG_LENGTH)) begin
         len_q <= csr_wdata[LEN_W-1:0];
      end else if (xfer_step) begin
         len_q <= xfer_last ? '0 : len_q - LEN_W'(xfer_size);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q   <= 1'b0;
         lenend_q <= 1'b0;
      end else if (srst_fire) begin
         done_q   <= 1'b0;
         lenend_q <= 1'b0;
      end else if (xfer_step && xfer_last) begin
         done_q   <= 1'b1;
         lenend_q <= 1'b1;
      end else if (start) begin
         done_q   <= 1'b0;
         lenend_q <= 1'b0;
      end else if (stat_we) begin
         done_q   <= 1'b0;
      end
   end

   assign irq = done_q && ctrl_q.ien;

   always_comb begin
      case (csr_addr)
         REG_STATUS: csr_rdata = {29'd0, lenend_q, busy, done_q};
         REG_RADDR:  csr_rdata = 32'(ptr[0]);
         REG_WADDR:  csr_rdata = 32'(ptr[1]);
         REG_LENGTH: csr_rdata = 32'(len_q);
         REG_CTRL:   csr_rdata = {19'd0, 1'b0, ctrl_q.wsel[4], ctrl_q.wsel[3],
                                  ctrl_q.whold, ctrl_q.rhold, 3'd0, ctrl_q.ien,
                                  1'b0, ctrl_q.wsel[2:0]};
         default:    csr_rdata = 32'd0;
      endcase
   end

endmodule

// File: rtl/dma_ctrl_engine_chk.sv
module dma_ctrl_engine_chk
   import dma_eng_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 128
)(
   input logic              clk,
   input logic              rst_n,
   input logic              csr_we,
   input logic [2:0]        csr_addr,
   input logic              m_rd_req,
   input logic [ADDR_W-1:0] m_rd_addr,
   input logic              m_wr_req,
   input logic [ADDR_W-1:0] m_wr_addr,
   input logic [DATA_W-1:0] m_wr_data,
   input logic              m_wr_ack,
   input logic              irq,
   input logic              busy,
   input logic              rhold,
   input logic              whold,
   input logic [SZ_W-1:0]   size,
   input logic              last,
   input logic              done,
   input logic              srst_fire
);

   logic step_q;
   assign step_q = m_wr_req && m_wr_ack && !csr_we;

   // R10: one request at a time
   a_r10_one_side: assert property (@(posedge clk) disable iff (!rst_n)
      !(m_rd_req && m_wr_req));

   // R6: requests only while a transfer is running
   a_r6_req_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (m_rd_req || m_wr_req) |-> busy);

   // R2: source pointer after a completed transfer
   a_r2_src_step: assert property (@(posedge clk) disable iff (!rst_n)
      step_q |=> m_rd_addr == ($past(rhold) ? $past(m_rd_addr)
                                            : $past(m_rd_addr) + ADDR_W'($past(size))));

   // R3: destination pointer after a completed transfer
   a_r3_dst_step: assert property (@(posedge clk) disable iff (!rst_n)
      step_q |=> m_wr_addr == ($past(whold) ? $past(m_wr_addr)
                                            : $past(m_wr_addr) + ADDR_W'($past(size))));

   // R5: final write ends the run
   a_r5_finish: assert property (@(posedge clk) disable iff (!rst_n)
      (step_q && last) |=> (done && !busy));

   // R8: status write acknowledges the interrupt
   a_r8_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_we && csr_addr == REG_STATUS && !(m_wr_req && m_wr_ack)) |=> !irq);

   // R10: pending write is held steady
   a_r10_wr_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (m_wr_req && !m_wr_ack && !csr_we) |=>
         (m_wr_req && $stable(m_wr_data) && $stable(m_wr_addr)));

   // R9: soft reset returns the engine to idle
   a_r9_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
      srst_fire |=> (!busy && !irq && m_rd_addr == '0 && m_wr_addr == '0));

endmodule

bind dma_ctrl_engine dma_ctrl_engine_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .csr_we    (csr_we),
   .csr_addr  (csr_addr),
   .m_rd_req  (m_rd_req),
   .m_rd_addr (m_rd_addr),
   .m_wr_req  (m_wr_req),
   .m_wr_addr (m_wr_addr),
   .m_wr_data (m_wr_data),
   .m_wr_ack  (m_wr_ack),
   .irq       (irq),
   .busy      (busy),
   .rhold     (rhold),
   .whold     (whold),
   .size      (xfer_size),
   .last      (xfer_last),
   .done      (done_q),
   .srst_fire (srst_fire)
);

// File: tb/tb_dma_ctrl_engine.sv
`timescale 1ns/1ps
module tb_dma_ctrl_engine;

   localparam int ADDR_W = 32;
   localparam int LEN_W  = 16;
   localparam int DATA_W = 128;
   localparam int LOG_N  = 256;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              csr_we = 1'b0;
   logic [2:0]        csr_addr = '0;
   logic [31:0]       csr_wdata = '0;
   logic [31:0]       csr_rdata;
   logic              m_rd_req;
   logic [ADDR_W-1:0] m_rd_addr;
   logic              m_rd_valid = 1'b0;
   logic [DATA_W-1:0] m_rd_data;
   logic              m_wr_req;
   logic [ADDR_W-1:0] m_wr_addr;
   logic [DATA_W-1:0] m_wr_data;
   logic              m_wr_ack = 1'b0;
   logic              irq;

   int tests = 0;
   int fails = 0;
   bit stall = 1'b0;
   bit finished = 1'b0;

   int                rd_n = 0;
   int                wr_n = 0;
   logic [ADDR_W-1:0] ra_log [LOG_N];
   logic [ADDR_W-1:0] wa_log [LOG_N];
   logic [DATA_W-1:0] wd_log [LOG_N];

   always #2.5 clk = ~clk;

   dma_ctrl_engine #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W)) dut (
      .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
      .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
      .m_rd_req(m_rd_req), .m_rd_addr(m_rd_addr), .m_rd_valid(m_rd_valid),
      .m_rd_data(m_rd_data), .m_wr_req(m_wr_req), .m_wr_addr(m_wr_addr),
      .m_wr_data(m_wr_data), .m_wr_ack(m_wr_ack), .irq(irq)
   );

   function automatic logic [DATA_W-1:0] mem_val(input logic [ADDR_W-1:0] a);
      logic [DATA_W-1:0] r;
      for (int i = 0; i < DATA_W/32; i++)
         r[i*32 +: 32] = (a * 32'h9E37_79B1) ^ (32'h1111_0000 * (i + 1));
      return r;
   endfunction

   // R4: width index -> control bit position
   function automatic int wbit(input int widx);
      case (widx)
         0: return 0;
         1: return 1;
         2: return 2;
         3: return 10;
         default: return 11;
      endcase
   endfunction

   assign m_rd_data = mem_val(m_rd_addr);

   // master-side responder, driven at the falling edge
   always @(negedge clk) begin
      if (!rst_n) begin
         m_rd_valid = 1'b0;
         m_wr_ack   = 1'b0;
      end else begin
         m_rd_valid = m_rd_req && !stall && ($urandom_range(0, 3) != 0);
         if (m_rd_valid) begin
            if (rd_n < LOG_N) ra_log[rd_n] = m_rd_addr;
            rd_n++;
         end
         m_wr_ack = m_wr_req && !stall && ($urandom_range(0, 3) != 0);
         if (m_wr_ack) begin
            if (wr_n < LOG_N) begin
               wa_log[wr_n] = m_wr_addr;
               wd_log[wr_n] = m_wr_data;
            end
            wr_n++;
         end
      end
   end

   task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic csr_write(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      csr_we = 1'b1; csr_addr = a; csr_wdata = d;
      @(negedge clk);
      csr_we = 1'b0;
   endtask

   task automatic csr_read(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      csr_addr = a;
      #1 d = csr_rdata;
   endtask

   task automatic wait_idle();
      logic [31:0] s;
      for (int k = 0; k < 4000; k++) begin
         csr_read(3'd0, s);
         if (!s[1]) break;
      end
   endtask

   task automatic run_xfer(input logic [31:0] ra, input logic [31:0] wa,
                           input int len, input int widx,
                           input bit rh, input bit wh, input bit ien);
      int          size;
      int          n;
      logic [31:0] v;
      logic [31:0] ctrl;
      logic [31:0] era;
      logic [31:0] ewa;
      size = 1 << widx;
      n    = (len + size - 1) / size;
      rd_n = 0; wr_n = 0;
      csr_write(3'd1, ra);
      csr_write(3'd2, wa);
      csr_write(3'd3, 32'(len));
      ctrl = (32'd1 << wbit(widx)) | (32'd1 << 3) | (32'(ien) << 4)
           | (32'(rh) << 8) | (32'(wh) << 9);
      csr_write(3'd4, ctrl);
      wait_idle();
      check("R5 transfer count", 128'(wr_n), 128'(n));
      check("R10 read count", 128'(rd_n), 128'(n));
      for (int i = 0; i < n && i < LOG_N; i++) begin
         era = rh ? ra : ra + 32'(i * size);
         ewa = wh ? wa : wa + 32'(i * size);
         check("R2 read address", 128'(ra_log[i]), 128'(era));
         check("R3 write address", 128'(wa_log[i]), 128'(ewa));
         check("R10 write data", wd_log[i], mem_val(era));
      end
      csr_read(3'd1, v);
      check("R2 final source", 128'(v), 128'(rh ? ra : ra + 32'(n * size)));
      csr_read(3'd2, v);
      check("R3 final dest", 128'(v), 128'(wh ? wa : wa + 32'(n * size)));
      csr_read(3'd3, v);
      check("R5 count zero", 128'(v), 128'(0));
      csr_read(3'd0, v);
      check("R5 status done/len", 128'(v), 128'(32'h5));
      check("R7 irq at end", 128'(irq), 128'(ien));
      csr_write(3'd0, 32'h0);
      csr_read(3'd0, v);
      check("R8 done cleared", 128'(v[0]), 128'(0));
      check("R8 irq cleared", 128'(irq), 128'(0));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         fails++;
         tests++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      for (int r = 0; r < 5; r++) begin
         csr_read(3'(r), v);
         check("R1 register zero", 128'(v), 128'(0));
      end
      check("R1 irq low", 128'(irq), 128'(0));
      check("R1 no requests", 128'({m_rd_req, m_wr_req}), 128'(0));

      // R4 every width, including a partial last chunk
      for (int w = 0; w < 5; w++)
         run_xfer(32'h1000_0000 + 32'(w * 256), 32'h2000_0000, 40, w, 1'b0, 1'b0, 1'b1);

      // R2 / R3 holds, each side alone
      run_xfer(32'h0000_4000, 32'h0000_8000, 12, 2, 1'b1, 1'b0, 1'b0);
      run_xfer(32'h0000_4000, 32'h0000_8000, 12, 2, 1'b0, 1'b1, 1'b1);

      // R6 illegal width (two bits)
      rd_n = 0;
      csr_write(3'd3, 32'd8);
      csr_write(3'd4, 32'h0000_000B);
      repeat (8) @(negedge clk);
      csr_read(3'd0, v);
      check("R6 two widths no busy", 128'(v[1]), 128'(0));
      check("R6 two widths no read", 128'(rd_n), 128'(0));
      // R6 zero count
      csr_write(3'd3, 32'd0);
      csr_write(3'd4, 32'h0000_0009);
      repeat (8) @(negedge clk);
      csr_read(3'd0, v);
      check("R6 zero count no busy", 128'(v[1]), 128'(0));
      check("R6 zero count no read", 128'(rd_n), 128'(0));

      // R7 irq masked when enable clear, then raised by enabling
      run_xfer(32'h100, 32'h200, 4, 0, 1'b0, 1'b0, 1'b0);
      csr_write(3'd3, 32'd2);
      csr_write(3'd4, 32'h0000_0009);
      wait_idle();
      check("R7 irq masked", 128'(irq), 128'(0));
      csr_write(3'd4, 32'h0000_0011);
      check("R7 irq on enable", 128'(irq), 128'(1));
      csr_write(3'd0, 32'hFFFF_FFFF);
      check("R8 irq acked", 128'(irq), 128'(0));

      // R9 disarm by intervening write
      csr_write(3'd1, 32'hABCD_0000);
      csr_write(3'd4, 32'h0000_1000);
      csr_write(3'd4, 32'h0000_0000);
      csr_write(3'd4, 32'h0000_1000);
      csr_read(3'd1, v);
      check("R9 disarmed keeps state", 128'(v), 128'(32'hABCD_0000));
      csr_write(3'd4, 32'h0000_1000);
      csr_read(3'd1, v);
      check("R9 second write resets", 128'(v), 128'(0));

      // R9 soft reset mid-transfer
      stall = 1'b1;
      csr_write(3'd1, 32'h500);
      csr_write(3'd2, 32'h600);
      csr_write(3'd3, 32'd64);
      csr_write(3'd4, 32'h0000_0019);
      csr_read(3'd0, v);
      check("R9 busy before reset", 128'(v[1]), 128'(1));
      csr_write(3'd4, 32'h0000_1000);
      csr_write(3'd4, 32'h0000_1000);
      stall = 1'b0;
      for (int r = 0; r < 5; r++) begin
         csr_read(3'(r), v);
         check("R9 register zero", 128'(v), 128'(0));
      end
      check("R9 no requests", 128'({m_rd_req, m_wr_req}), 128'(0));

      // constrained random
      for (int t = 0; t < 24; t++) begin
         run_xfer($urandom, $urandom, $urandom_range(1, 64), $urandom_range(0, 4),
                  1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                  1'($urandom_range(0, 1)));
      end

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule